// File: doc/BRIEF.md
# Zero-Suppressed Serial Readout Formatter

This block turns the stored hit data of one front-end chip into a bit stream on a single data line. The stream is built from 16-bit words and sent most significant bit first. The first word always carries the chip identifier. After it, the block visits the channels in ascending order. Channels with no stored events are skipped. Each channel with events gets one header word, followed by one data word per stored event. A data-valid strobe marks every bit that is driven.

Several chips share one line and take turns by passing a token. A one-cycle pulse on the token input starts a readout. When the last bit has left, the block raises token-out for one clock, and the next chip then takes over. A mode input chooses what an empty chip does: it either passes the token on without sending anything, or it sends its identifier word alone.

Event payloads are fetched through a synchronous read port with one cycle of latency. The address of each payload is formed from the channel number and the event index. Per-channel event counts arrive as a flat vector. They must stay stable while a readout is in progress.

Top module: `sparse_readout_tx`

## Requirements
- R1: While reset is high and in the cycle after it, sdata, sdata_valid, token_out and mem_rd_en are all 0.
- R2: Suppose token_in is sampled high while the block is idle and at least one word is due. Then sdata_valid rises in the next cycle and stays high with no gap for 16 cycles per word. Each word is sent MSB first.
- R3: The first word is the identifier word. Bits [15:9] are 0, bits [8:1] hold chip_id, and bit 0 is parity.
- R4: Only channels whose count is nonzero are sent, in ascending channel order. Each one starts with a header word: [15]=1, [14:9]=channel, [8:5]=event count, [4:1]=0, [0]=parity.
- R5: Each header is followed by exactly count data words, for events 0 up to count-1 in order. A data word is laid out as [15]=0, [14:1]=mem_rd_data (a 12-bit time stamp above a 2-bit hit code), [0]=parity.
- R6: Bit 0 of every word makes the number of ones in bits [15:0] even.
- R7: A per-channel count (4 bits per channel in ch_count, channel c at bits [4c+3:4c]) above 8 is treated as 8, in both the header field and the number of data words.
- R8: If all counts are 0 and always_id is 0, no bit is driven. token_out is then high for one cycle, in the cycle right after token_in was sampled.
- R9: If all counts are 0 and always_id is 1, only the identifier word is sent.
- R10: token_out is high for exactly one cycle, in the cycle right after the last valid bit, and never together with sdata_valid.
- R11: token_in pulses that arrive while a readout is in progress are ignored. They do not change the stream or the token timing, and they do not start a second readout.
- R12: mem_rd_en is a one-cycle pulse with mem_rd_addr = {channel[5:0], event[2:0]}. Data is taken from mem_rd_data one cycle later. There is exactly one read per data word sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| token_in | input | 1 | One-cycle pulse that starts a readout when the block is idle |
| always_id | input | 1 | 1: an empty chip still sends its identifier word |
| chip_id | input | 8 | Chip identifier |
| ch_count | input | 256 | Stored event count per channel, 4 bits each |
| mem_rd_en | output | 1 | Event memory read strobe |
| mem_rd_addr | output | 9 | Event memory address {channel, event} |
| mem_rd_data | input | 14 | Event payload {time stamp, hit code}, valid one cycle after the read |
| sdata | output | 1 | Serial data, MSB first |
| sdata_valid | output | 1 | Marks driven bits of sdata |
| token_out | output | 1 | One-cycle token pass to the next chip |

## Verification
The bench aims at the edges of the channel scan:
- Hits on channel 0 and channel 63 are covered. A scan that wrapped its pointer after the top channel would repeat headers.
- A scan that missed the lowest channel would drop its data.
- Sparse hit patterns are covered. A formatter that did not skip empty channels would insert headers with a zero count.

Counts of 8, and counts above 8, exercise the saturation path. Without it, the event field would overflow and memory would be read past the stored events. Both empty-chip modes are run, and the token is checked to arrive exactly 16 cycles per word after the start: a late or doubled token would let two chips drive the line at once. A full chip of 577 words confirms that the stream stays continuous. A token pulse injected mid-stream shows whether a busy block would restart.

// File: rtl/srt_pkg.sv
package srt_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_FIN
  } rd_state_e;

  typedef enum logic [1:0] {
    W_ID,
    W_HDR,
    W_DAT
  } word_kind_e;
endpackage

// File: rtl/srt_chan_scan.sv
// Finds the lowest channel at or above 'start' whose event count is nonzero.
module srt_chan_scan #(
  parameter int NCH   = 64,
  parameter int CNT_W = 4,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic [NCH*CNT_W-1:0] cnt_flat,
  input  logic [CH_W:0]        start,
  output logic                 found,
  output logic [CH_W-1:0]      idx,
  output logic [CNT_W-1:0]     cnt
);
  logic [NCH-1:0] elig;

  for (genvar i = 0; i < NCH; i++) begin : g_elig
    assign elig[i] = (|cnt_flat[i*CNT_W +: CNT_W]) && ((CH_W+1)'(i) >= start);
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end

  assign cnt = cnt_flat[idx*CNT_W +: CNT_W];
endmodule

// File: rtl/srt_word_fmt.sv
// Builds one 16-bit output word of the requested kind and seals it with even parity.
module srt_word_fmt
  import srt_pkg::*;
#(
  parameter int CH_W = 6,
  parameter int CF_W = 4,
  parameter int ID_W = 8,
  parameter int ED_W = 14
) (
  input  word_kind_e          kind,
  input  logic [ID_W-1:0]     chip_id,
  input  logic [CH_W-1:0]     ch,
  input  logic [CF_W-1:0]     cnt,
  input  logic [ED_W-1:0]     evd,
  output logic [WORD_W-1:0]   word
);
  localparam int HPAD  = WORD_W - 2 - CH_W - CF_W;
  localparam int IDPAD = WORD_W - 1 - ID_W;

  logic [WORD_W-1:0] raw;

  always_comb begin
    case (kind)
      W_ID:    raw = {{IDPAD{1'b0}}, chip_id, 1'b0};
      W_HDR:   raw = {1'b1, ch, cnt, {HPAD{1'b0}}, 1'b0};
      default: raw = {1'b0, evd, 1'b0};
    endcase
  end

  assign word = {raw[WORD_W-1:1], ^raw[WORD_W-1:1]};
endmodule

// File: rtl/srt_piso.sv
// Parallel-in serial-out shifter, MSB first, with registered data and valid.
module srt_piso #(
  parameter int W = 16,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sdo,
  output logic         vld,
  output logic         ready,
  output logic         last
);
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh  <= '0;
      cnt <= '0;
      vld <= 1'b0;
    end else if (load) begin
      sh  <= din;
      cnt <= CW'(W);
      vld <= 1'b1;
    end else if (vld) begin
      sh  <= {sh[W-2:0], 1'b0};
      cnt <= cnt - 1'b1;
      vld <= (cnt != CW'(1));
    end
  end

  assign sdo   = sh[W-1];
  assign last  = vld && (cnt == CW'(1));
  assign ready = !vld || last;

  // A new word may only replace the shifter contents once the old one is leaving.
  assert_load_when_ready_R2: assert property (@(posedge clk) disable iff (rst)
    load |-> ready);

  // After a load, exactly W valid cycles follow before the line falls idle.
  assert_bit_count_R2: assert property (@(posedge clk) disable iff (rst)
    (vld && !load && cnt == CW'(1)) |=> !vld);
endmodule

// File: rtl/sparse_readout_tx.sv
module sparse_readout_tx
  import srt_pkg::*;
#(
  parameter int NCH     = 64,
  parameter int EVT_MAX = 8,
  parameter int TS_W    = 12,
  parameter int HIT_W   = 2,
  parameter int ID_W    = 8,
  parameter int CNT_W   = 4,
  localparam int CH_W   = $clog2(NCH),
  localparam int EV_W   = $clog2(EVT_MAX),
  localparam int CF_W   = $clog2(EVT_MAX + 1),
  localparam int ED_W   = TS_W + HIT_W,
  localparam int AW     = CH_W + EV_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 token_in,
  input  logic                 always_id,
  input  logic [ID_W-1:0]      chip_id,
  input  logic [NCH*CNT_W-1:0] ch_count,
  output logic                 mem_rd_en,
  output logic [AW-1:0]        mem_rd_addr,
  input  logic [ED_W-1:0]      mem_rd_data,
  output logic                 sdata,
  output logic                 sdata_valid,
  output logic                 token_out
);
  rd_state_e         state;
  logic [CH_W:0]     ch_ptr;
  logic [CH_W-1:0]   cur_ch;
  logic [CF_W-1:0]   ev_tot;
  logic [CF_W-1:0]   snd_idx;
  logic [CF_W-1:0]   nxt_idx;
  logic              rd_en_q;
  logic [AW-1:0]     rd_addr_q;
  logic              pend;
  logic              have;
  logic [ED_W-1:0]   ebuf;
  logic              tok_q;

  logic [CH_W:0]     scan_start;
  logic              scan_found;
  logic [CH_W-1:0]   scan_idx;
  logic [CNT_W-1:0]  raw_cnt;
  logic [CF_W-1:0]   sat_cnt;

  logic              ld;
  word_kind_e        kind;
  logic [WORD_W-1:0] word;
  logic              sh_ready;
  logic              sh_last;

  // ---------------- channel scan ----------------
  assign scan_start = (state == ST_IDLE) ? '0 : ch_ptr;

  srt_chan_scan #(.NCH(NCH), .CNT_W(CNT_W)) u_scan (
    .cnt_flat (ch_count),
    .start    (scan_start),
    .found    (scan_found),
    .idx      (scan_idx),
    .cnt      (raw_cnt)
  );

  assign sat_cnt = (raw_cnt > CNT_W'(EVT_MAX)) ? CF_W'(EVT_MAX) : CF_W'(raw_cnt);
  assign nxt_idx = snd_idx + 1'b1;

  // ---------------- word selection and load ----------------
  always_comb begin
    ld   = 1'b0;
    kind = W_DAT;
    case (state)
      ST_IDLE: begin
        kind = W_ID;
        ld   = token_in && (scan_found || always_id);
      end
      ST_HDR: begin
        kind = W_HDR;
        ld   = scan_found && sh_ready;
      end
      ST_DATA: begin
        kind = W_DAT;
        ld   = have && sh_ready;
      end
      default: begin
        kind = W_DAT;
        ld   = 1'b0;
      end
    endcase
  end

  srt_word_fmt #(.CH_W(CH_W), .CF_W(CF_W), .ID_W(ID_W), .ED_W(ED_W)) u_fmt (
    .kind    (kind),
    .chip_id (chip_id),
    .ch      (scan_idx),
    .cnt     (sat_cnt),
    .evd     (ebuf),
    .word    (word)
  );

  srt_piso #(.W(WORD_W)) u_piso (
    .clk   (clk),
    .rst   (rst),
    .load  (ld),
    .din   (word),
    .sdo   (sdata),
    .vld   (sdata_valid),
    .ready (sh_ready),
    .last  (sh_last)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ch_ptr    <= '0;
      cur_ch    <= '0;
      ev_tot    <= '0;
      snd_idx   <= '0;
      rd_en_q   <= 1'b0;
      rd_addr_q <= '0;
      pend      <= 1'b0;
      have      <= 1'b0;
      ebuf      <= '0;
      tok_q     <= 1'b0;
    end else begin
      rd_en_q <= 1'b0;
      tok_q   <= 1'b0;
      pend    <= rd_en_q;
      if (pend) begin
        ebuf <= mem_rd_data;
        have <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (token_in) begin
            if (scan_found || always_id) begin
              ch_ptr <= '0;
              state  <= ST_HDR;
            end else begin
              tok_q <= 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (!scan_found) begin
            state <= ST_FIN;
          end else if (sh_ready) begin
            cur_ch    <= scan_idx;
            ev_tot    <= sat_cnt;
            snd_idx   <= '0;
            rd_en_q   <= 1'b1;
            rd_addr_q <= {scan_idx, {EV_W{1'b0}}};
            state     <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (have && sh_ready) begin
            have    <= 1'b0;
            snd_idx <= nxt_idx;
            if (nxt_idx < ev_tot) begin
              rd_en_q   <= 1'b1;
              rd_addr_q <= {cur_ch, nxt_idx[EV_W-1:0]};
            end else begin
              ch_ptr <= {1'b0, cur_ch} + 1'b1;
              state  <= ST_HDR;
            end
          end
        end
        ST_FIN: begin
          if (sh_last) begin
            tok_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_en   = rd_en_q;
  assign mem_rd_addr = rd_addr_q;
  assign token_out   = tok_q;

  // ---------------- assertions ----------------
  assert_tok_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    token_out |=> !token_out);

  assert_tok_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    token_out |-> !sdata_valid);

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  assert_hdr_cnt_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR && ld) |-> (sat_cnt != '0 && sat_cnt <= CF_W'(EVT_MAX)));

  assert_data_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA) |-> (snd_idx < ev_tot));

  assert_idle_silent_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sdata_valid);
endmodule

// File: tb/sim_sparse_readout_tx.sv
`timescale 1ns/1ps
module sim_sparse_readout_tx;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         token_in = 1'b0;
  logic         always_id = 1'b0;
  logic [7:0]   chip_id = 8'h00;
  logic [255:0] ch_count = '0;
  logic         mem_rd_en;
  logic [8:0]   mem_rd_addr;
  logic [13:0]  mem_rd_data = '0;
  logic         sdata;
  logic         sdata_valid;
  logic         token_out;

  always #4 clk = ~clk;

  sparse_readout_tx u0 (
    .clk         (clk),
    .rst         (rst),
    .token_in    (token_in),
    .always_id   (always_id),
    .chip_id     (chip_id),
    .ch_count    (ch_count),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .sdata       (sdata),
    .sdata_valid (sdata_valid),
    .token_out   (token_out)
  );

  int seed = 0;
  int cnt_arr [64];

  function automatic logic [13:0] ev_val(input logic [8:0] a, input int s);
    ev_val = 14'((int'(a) * 29 + s * 7 + 3) ^ (int'(a) << 5));
  endfunction

  function automatic logic [15:0] seal(input logic [15:0] w);
    seal = {w[15:1], ^w[15:1]};
  endfunction

  // event memory model: one-cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= ev_val(mem_rd_addr, seed);

  logic [15:0] expq [$];
  int checks = 0, fails = 0;
  int mon_checks = 0, mon_fails = 0;
  int vcnt = 0, rdcnt = 0, nb = 0;
  logic [15:0] shreg = '0;
  bit finished = 0;

  // monitor: assembles words and compares against the scoreboard queue
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en) rdcnt++;
      if (sdata_valid) begin
        shreg = {shreg[14:0], sdata};
        nb++;
        vcnt++;
        if (nb == 16) begin
          nb = 0;
          mon_checks++;
          if (expq.size() == 0) begin
            mon_fails++;
            $display("FAIL R3/R4/R5/R6 unexpected word: got %h expected none", shreg);
          end else begin
            logic [15:0] e;
            e = expq.pop_front();
            if (shreg !== e) begin
              mon_fails++;
              $display("FAIL R3/R4/R5/R6/R7 word: got %h expected %h", shreg, e);
            end
          end
        end
      end
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clear_counts();
    for (int c = 0; c < 64; c++) cnt_arr[c] = 0;
  endtask

  // driver: builds the expected word list, starts a readout, checks token timing
  task automatic run_readout(input logic aid, input logic [7:0] id, input int sd, input bit retrig);
    int nw = 0, nrd = 0, k = 0, any = 0;
    seed = sd;
    always_id = aid;
    chip_id = id;
    for (int c = 0; c < 64; c++) begin
      ch_count[c*4 +: 4] = 4'(cnt_arr[c]);
      if (cnt_arr[c] != 0) any = 1;
    end
    expq.delete();
    if (any != 0 || aid) begin
      expq.push_back(seal({7'b0, id, 1'b0}));
      for (int c = 0; c < 64; c++) begin
        if (cnt_arr[c] != 0) begin
          int s;
          s = (cnt_arr[c] > 8) ? 8 : cnt_arr[c];
          expq.push_back(seal({1'b1, 6'(c), 4'(s), 4'b0, 1'b0}));
          for (int e = 0; e < s; e++)
            expq.push_back(seal({1'b0, ev_val({6'(c), 3'(e)}, sd), 1'b0}));
          nrd += s;
        end
      end
    end
    nw = expq.size();
    @(negedge clk);
    vcnt = 0;
    rdcnt = 0;
    nb = 0;
    token_in = 1'b1;
    while (k < 20000) begin
      @(negedge clk);
      k++;
      if (k == 1) token_in = 1'b0;
      if (retrig && k == 40) token_in = 1'b1;
      if (retrig && k == 41) token_in = 1'b0;
      if (token_out) break;
    end
    check(aid ? "R10/R9 token cycle" : "R10/R8 token cycle", k, 16 * nw + 1);
    check("R2 contiguous valid bits", vcnt, 16 * nw);
    check("R4/R5 words left in scoreboard", expq.size(), 0);
    check("R12 memory reads", rdcnt, nrd);
    repeat (30) begin
      @(negedge clk);
      if (sdata_valid || token_out) break;
    end
    check("R11 no activity after token", int'(sdata_valid || token_out), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R1 sdata_valid in reset", int'(sdata_valid), 0);
    check("R1 token_out in reset", int'(token_out), 0);
    check("R1 mem_rd_en in reset", int'(mem_rd_en), 0);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check("R1 sdata after reset", int'(sdata), 0);
    check("R1 sdata_valid after reset", int'(sdata_valid), 0);

    // two sparse channels
    clear_counts(); cnt_arr[20] = 2; cnt_arr[43] = 3;
    run_readout(1'b0, 8'hE2, 1, 1'b0);

    // edges of the channel range, full and single counts (R4)
    clear_counts(); cnt_arr[0] = 8; cnt_arr[1] = 1; cnt_arr[31] = 5; cnt_arr[63] = 1;
    run_readout(1'b1, 8'h5A, 2, 1'b0);

    // saturation of counts above 8 (R7)
    clear_counts(); cnt_arr[7] = 12; cnt_arr[62] = 15; cnt_arr[63] = 9;
    run_readout(1'b0, 8'h01, 3, 1'b0);

    // empty chip, silent mode (R8)
    clear_counts();
    run_readout(1'b0, 8'h3C, 4, 1'b0);

    // empty chip, identifier only (R9)
    clear_counts();
    run_readout(1'b1, 8'hA5, 5, 1'b0);

    // token pulse during a busy readout is ignored (R11)
    clear_counts(); cnt_arr[5] = 4; cnt_arr[9] = 2;
    run_readout(1'b0, 8'h77, 6, 1'b1);

    // every channel full: 577 words (R2)
    for (int c = 0; c < 64; c++) cnt_arr[c] = 8;
    run_readout(1'b0, 8'hFF, 7, 1'b0);

    // alternating pattern
    for (int c = 0; c < 64; c++) cnt_arr[c] = (c % 3 == 0) ? (c % 9) : 0;
    run_readout(1'b1, 8'h80, 8, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks + mon_checks, fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks + mon_checks + 1, fails + mon_fails + 1);
      $finish;
    end
  end
endmodule